// File: doc/BRIEF.md
# H-Bridge Switch Sequencer with Protection

This block turns three command bits (pulse-width, direction, brake) into the four gate enables of a full bridge: a high and a low switch on each of two half-bridges. Each command bit first passes a minimum-width filter, so a glitch shorter than the configured cycle count never reaches the switches. The filtered commands are decoded into one of five switch patterns: drive one way, drive the other way, both high sides on, both low sides on, or all switches off.

A break-before-make sequencer sits between the decoder and the gate pins. A switch that has to turn off is released on the next clock. A switch that has to turn on is held back until a programmable number of idle cycles has passed since the last release. Protection logic watches a digitized junction temperature, a digitized supply voltage and an overcurrent comparator bit. A thermal warning is raised at a lower threshold and leaves the bridge running. A thermal shutdown at a higher threshold, or an undervoltage lockout, turns every switch off. Both thresholds have programmable hysteresis. An overcurrent event turns the bridge off and retries after a programmable interval.

Top module: `hbridge_ctrl`

## Requirements
- R1: With filtered pulse-width high and brake low, direction high gives gate_o = 4'b1001 and direction low gives gate_o = 4'b0110. The gate_o bit order is {hs1, ls1, hs2, ls2}.
- R2: With pulse-width low and brake low, gate_o settles to 4'b1010 (both high sides on) for either direction.
- R3: With pulse-width high and brake high, direction high gives 4'b1010 and direction low gives 4'b0101.
- R4: With pulse-width low and brake high, gate_o settles to 4'b0000.
- R5: A command input change held for fewer than MIN_PW cycles has no effect on gate_o. A change held for MIN_PW cycles updates the filtered command at the MIN_PW-th clock edge.
- R6: A switch that must turn off drops on the clock edge after the filtered command or the fault state changes. No switch turns on until at least cfg_dead_i+1 cycles after the most recent turn-off. The high and low switch of one half-bridge are never on together.
- R7: therm_warn_no goes low one cycle after temp_i >= cfg_t_warn_i. It returns high only when temp_i + cfg_t_hyst_i < cfg_t_warn_i. The warning alone does not change gate_o.
- R8: temp_i >= cfg_t_shdn_i sets fault_o[1] and forces gate_o to zero. The fault clears only when temp_i + cfg_t_hyst_i < cfg_t_shdn_i.
- R9: vsup_i < cfg_uv_on_i sets fault_o[2] and forces gate_o to zero. The fault clears only when vsup_i >= cfg_uv_on_i + cfg_uv_hyst_i.
- R10: oc_i high while the bridge is enabled sets fault_o[0] and turns all switches off. After max(cfg_retry_i,1) cycles the bridge is re-enabled for one probe cycle. fault_o[0] clears only if oc_i is low in that probe cycle; otherwise another wait begins.
- R11: During reset gate_o is 0, therm_warn_no is 1 and fault_o is 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Pulse-width command |
| dir_i | input | 1 | Direction command |
| brake_i | input | 1 | Brake command |
| temp_i | input | TEMP_W | Junction temperature code |
| vsup_i | input | VS_W | Supply voltage code |
| oc_i | input | 1 | Overcurrent comparator output |
| cfg_dead_i | input | DT_W | Dead-time cycle count |
| cfg_retry_i | input | RT_W | Overcurrent retry interval in cycles |
| cfg_t_warn_i | input | TEMP_W | Thermal warning threshold |
| cfg_t_shdn_i | input | TEMP_W | Thermal shutdown threshold |
| cfg_t_hyst_i | input | TEMP_W | Thermal hysteresis |
| cfg_uv_on_i | input | VS_W | Undervoltage trip level |
| cfg_uv_hyst_i | input | VS_W | Undervoltage hysteresis |
| gate_o | output | 4 | Gate enables {hs1, ls1, hs2, ls2} |
| therm_warn_no | output | 1 | Thermal warning, active low |
| fault_o | output | 3 | {undervoltage, thermal shutdown, overcurrent} |

## Verification
The bench targets the first edge of the pulse filter. A pulse one cycle too short must leave the gates untouched, and a filter off by one would let it through or lag by a cycle. On a direction or brake change it checks the intermediate state with only the releasing switch dropped. A sequencer that swapped make and break order, or counted the dead time from the wrong edge, would briefly short a leg or turn a switch on early. Readings inside the hysteresis bands must keep the faults set, which catches a design that compares against the bare threshold and chatters. A held overcurrent must keep its fault bit set across every retry, and a single overcurrent pulse must clear it after exactly one wait interval.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int G_HS1 = 3;
  localparam int G_LS1 = 2;
  localparam int G_HS2 = 1;
  localparam int G_LS2 = 0;

  localparam int F_OC  = 0;
  localparam int F_OT  = 1;
  localparam int F_UV  = 2;

  typedef enum logic [1:0] {
    OC_RUN   = 2'd0,
    OC_WAIT  = 2'd1,
    OC_PROBE = 2'd2
  } oc_state_e;
endpackage

// File: rtl/hb_pulse_filter.sv
module hb_pulse_filter #(
  parameter int MIN_PW = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (MIN_PW > 2) ? $clog2(MIN_PW) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_PW - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  // output follows raw only after MIN_PW consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      filt_q <= raw_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  logic       pwm_i,
  input  logic       dir_i,
  input  logic       brake_i,
  output logic [3:0] want_o
);
  always_comb begin
    want_o = '0;
    unique case ({pwm_i, brake_i})
      2'b10: begin
        want_o[G_HS1] = dir_i;
        want_o[G_LS2] = dir_i;
        want_o[G_LS1] = !dir_i;
        want_o[G_HS2] = !dir_i;
      end
      2'b00: begin
        want_o[G_HS1] = 1'b1;
        want_o[G_HS2] = 1'b1;
      end
      2'b11: begin
        want_o[G_HS1] = dir_i;
        want_o[G_HS2] = dir_i;
        want_o[G_LS1] = !dir_i;
        want_o[G_LS2] = !dir_i;
      end
      default: want_o = '0;
    endcase
  end
endmodule

// File: rtl/hb_level_mon.sv
module hb_level_mon #(
  parameter int   W         = 8,
  parameter bit   TRIP_HIGH = 1'b1,
  parameter logic RST_VAL   = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] code_i,
  input  logic [W-1:0] thr_i,
  input  logic [W-1:0] hyst_i,
  output logic         trip_o
);
  logic         trip_q;
  logic         set_c;
  logic         clr_c;
  logic [W:0]   code_x;
  logic [W:0]   thr_x;
  logic [W:0]   hyst_x;

  assign code_x = {1'b0, code_i};
  assign thr_x  = {1'b0, thr_i};
  assign hyst_x = {1'b0, hyst_i};

  generate
    if (TRIP_HIGH) begin : g_over
      assign set_c = code_x >= thr_x;
      assign clr_c = (code_x + hyst_x) < thr_x;
    end else begin : g_under
      assign set_c = code_x < thr_x;
      assign clr_c = code_x >= (thr_x + hyst_x);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trip_q <= RST_VAL;
    else if (set_c)  trip_q <= 1'b1;
    else if (clr_c)  trip_q <= 1'b0;
  end

  assign trip_o = trip_q;
endmodule

// File: rtl/hb_oc_retry.sv
module hb_oc_retry
  import hb_pkg::*;
#(
  parameter int RT_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            oc_i,
  input  logic [RT_W-1:0] cfg_retry_i,
  output logic            allow_o,
  output logic            fault_o
);
  oc_state_e       state_q;
  logic [RT_W-1:0] tmr_q;
  logic            fault_q;
  logic [RT_W:0]   tmr_nxt;

  assign tmr_nxt = {1'b0, tmr_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OC_RUN;
      tmr_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        OC_RUN: if (oc_i) begin
          state_q <= OC_WAIT;
          tmr_q   <= '0;
          fault_q <= 1'b1;
        end
        OC_WAIT: begin
          if (tmr_nxt >= {1'b0, cfg_retry_i}) state_q <= OC_PROBE;
          else                                tmr_q   <= tmr_nxt[RT_W-1:0];
        end
        OC_PROBE: begin
          if (oc_i) begin
            state_q <= OC_WAIT;
            tmr_q   <= '0;
          end else begin
            state_q <= OC_RUN;
            fault_q <= 1'b0;
          end
        end
        default: state_q <= OC_RUN;
      endcase
    end
  end

  assign allow_o = (state_q != OC_WAIT);
  assign fault_o = fault_q;
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      target_i,
  input  logic [DT_W-1:0] cfg_dead_i,
  output logic [3:0]      gate_o
);
  logic [3:0]      gate_q;
  logic [3:0]      off_m;
  logic [3:0]      on_m;
  logic [DT_W-1:0] cnt_q;

  assign off_m = gate_q & ~target_i;
  assign on_m  = target_i & ~gate_q;

  // releases first; turn-ons wait for the dead count with nothing left to release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      cnt_q  <= '0;
    end else if (|off_m) begin
      gate_q <= gate_q & target_i;
      cnt_q  <= '0;
    end else if (|on_m) begin
      if (cnt_q >= cfg_dead_i) begin
        gate_q <= target_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int MIN_PW = 50,
  parameter int TEMP_W = 8,
  parameter int VS_W   = 8,
  parameter int DT_W   = 8,
  parameter int RT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic              dir_i,
  input  logic              brake_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [VS_W-1:0]   vsup_i,
  input  logic              oc_i,
  input  logic [DT_W-1:0]   cfg_dead_i,
  input  logic [RT_W-1:0]   cfg_retry_i,
  input  logic [TEMP_W-1:0] cfg_t_warn_i,
  input  logic [TEMP_W-1:0] cfg_t_shdn_i,
  input  logic [TEMP_W-1:0] cfg_t_hyst_i,
  input  logic [VS_W-1:0]   cfg_uv_on_i,
  input  logic [VS_W-1:0]   cfg_uv_hyst_i,
  output logic [3:0]        gate_o,
  output logic              therm_warn_no,
  output logic [2:0]        fault_o
);
  localparam int NCMD = 3;

  logic [NCMD-1:0] cmd_raw;
  logic [NCMD-1:0] cmd_f;
  logic [3:0]      want;
  logic [3:0]      target;
  logic            warn;
  logic            ot;
  logic            uv;
  logic            oc_allow;
  logic            oc_fault;
  logic            enable;

  assign cmd_raw = {brake_i, dir_i, pwm_i};

  generate
    for (genvar i = 0; i < NCMD; i++) begin : g_filt
      hb_pulse_filter #(.MIN_PW(MIN_PW)) u_filt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (cmd_raw[i]),
        .filt_o(cmd_f[i])
      );
    end
  endgenerate

  hb_decode u_dec (
    .pwm_i  (cmd_f[0]),
    .dir_i  (cmd_f[1]),
    .brake_i(cmd_f[2]),
    .want_o (want)
  );

  hb_level_mon #(.W(TEMP_W), .TRIP_HIGH(1'b1), .RST_VAL(1'b0)) u_warn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(temp_i),
    .thr_i (cfg_t_warn_i),
    .hyst_i(cfg_t_hyst_i),
    .trip_o(warn)
  );

  hb_level_mon #(.W(TEMP_W), .TRIP_HIGH(1'b1), .RST_VAL(1'b0)) u_ot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(temp_i),
    .thr_i (cfg_t_shdn_i),
    .hyst_i(cfg_t_hyst_i),
    .trip_o(ot)
  );

  // locked out from reset until the supply is seen good
  hb_level_mon #(.W(VS_W), .TRIP_HIGH(1'b0), .RST_VAL(1'b1)) u_uv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(vsup_i),
    .thr_i (cfg_uv_on_i),
    .hyst_i(cfg_uv_hyst_i),
    .trip_o(uv)
  );

  hb_oc_retry #(.RT_W(RT_W)) u_oc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .oc_i       (oc_i),
    .cfg_retry_i(cfg_retry_i),
    .allow_o    (oc_allow),
    .fault_o    (oc_fault)
  );

  assign enable = oc_allow && !ot && !uv;
  assign target = enable ? want : 4'b0000;

  hb_deadtime #(.DT_W(DT_W)) u_dt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .target_i  (target),
    .cfg_dead_i(cfg_dead_i),
    .gate_o    (gate_o)
  );

  assign therm_warn_no = !warn;
  always_comb begin
    fault_o       = '0;
    fault_o[F_OC] = oc_fault;
    fault_o[F_OT] = ot;
    fault_o[F_UV] = uv;
  end
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk #(
  parameter int TEMP_W = 8,
  parameter int DT_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TEMP_W-1:0] temp_i,
  input logic [TEMP_W-1:0] cfg_t_warn_i,
  input logic [DT_W-1:0]   cfg_dead_i,
  input logic [3:0]        gate_o,
  input logic              therm_warn_no,
  input logic [2:0]        fault_o
);
  logic [3:0]    gate_q;
  logic [DT_W:0] since_q;
  logic          fall;
  logic          rise;

  assign fall = |(gate_q & ~gate_o);
  assign rise = |(~gate_q & gate_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= '0;
      since_q <= '0;
    end else begin
      gate_q <= gate_o;
      if (fall)              since_q <= '0;
      else if (!(&since_q))  since_q <= since_q + 1'b1;
    end
  end

  AST_LEG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[3] && gate_o[2]) && !(gate_o[1] && gate_o[0])); // R6

  AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |-> (!fall && since_q >= {1'b0, cfg_dead_i})); // R6

  AST_WARN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= cfg_t_warn_i) |=> !therm_warn_no); // R7

  AST_HARD_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o[1] || fault_o[2]) |=> (gate_o == 4'b0000)); // R8 R9

  AST_OC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o[0]) |=> (gate_o == 4'b0000)); // R10
endmodule

bind hbridge_ctrl hbridge_ctrl_chk #(.TEMP_W(TEMP_W), .DT_W(DT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .temp_i       (temp_i),
  .cfg_t_warn_i (cfg_t_warn_i),
  .cfg_dead_i   (cfg_dead_i),
  .gate_o       (gate_o),
  .therm_warn_no(therm_warn_no),
  .fault_o      (fault_o)
);

// File: tb/tb_hbridge_ctrl.sv
module tb_hbridge_ctrl;
  localparam int MIN_PW = 50;
  localparam int DEAD   = 5;
  localparam int RETRY  = 200;
  localparam int SETTLE = MIN_PW + DEAD + 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm = 1'b0, dir = 1'b0, brk = 1'b0, oc = 1'b0;
  logic [7:0]  temp = 8'd40;
  logic [7:0]  vsup = 8'd200;
  logic [3:0]  gate;
  logic        warn_n;
  logic [2:0]  fault;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hbridge_ctrl #(.MIN_PW(MIN_PW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pwm_i(pwm), .dir_i(dir), .brake_i(brk),
    .temp_i(temp), .vsup_i(vsup), .oc_i(oc),
    .cfg_dead_i(8'(DEAD)), .cfg_retry_i(16'(RETRY)),
    .cfg_t_warn_i(8'd100), .cfg_t_shdn_i(8'd120), .cfg_t_hyst_i(8'd4),
    .cfg_uv_on_i(8'd80), .cfg_uv_hyst_i(8'd6),
    .gate_o(gate), .therm_warn_no(warn_n), .fault_o(fault)
  );

  function automatic logic [3:0] exp_gate(logic p, logic d, logic b);
    if (p && !b)  return d ? 4'b1001 : 4'b0110;
    if (!p && !b) return 4'b1010;
    if (p && b)   return d ? 4'b1010 : 4'b0101;
    return 4'b0000;
  endfunction

  function automatic string req_of(logic p, logic b);
    if (p && !b)  return "R1";
    if (!p && !b) return "R2";
    if (p && b)   return "R3";
    return "R4";
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // dead-time and leg monitor
  logic [3:0] mon_prev = 4'b0;
  int         since    = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (|(mon_prev & ~gate)) since = 0;
      else                     since = since + 1;
      if (|(~mon_prev & gate)) chk("R6_gap", 8'(since >= DEAD + 1), 8'd1);
      if ((gate[3] && gate[2]) || (gate[1] && gate[0])) chk("R6_leg", {4'b0, gate}, 8'd0);
      mon_prev = gate;
    end else begin
      mon_prev = 4'b0;
      since    = 0;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    // R11 reset values
    chk("R11_gate",  {4'b0, gate}, 8'h00);
    chk("R11_warn",  {7'b0, warn_n}, 8'h01);
    chk("R11_fault", {5'b0, fault}, 8'h04);
    rst_n = 1'b1;
    tick(SETTLE);
    chk("R2", {4'b0, gate}, {4'b0, exp_gate(0, 0, 0)});
    chk("R9_clear", {5'b0, fault}, 8'h00);

    // directed truth table rows
    for (int r = 0; r < 8; r++) begin
      pwm = r[0]; dir = r[1]; brk = r[2];
      tick(SETTLE);
      chk(req_of(pwm, brk), {4'b0, gate}, {4'b0, exp_gate(pwm, dir, brk)});
    end

    // R5: short pulse ignored, exact-length change honored
    pwm = 1; dir = 1; brk = 0;
    tick(SETTLE);
    chk("R1", {4'b0, gate}, 8'h09);
    pwm = 0;
    tick(MIN_PW - 1);
    pwm = 1;
    begin
      int bad = 0;
      for (int i = 0; i < 2 * MIN_PW; i++) begin
        tick(1);
        if (gate !== 4'b1001) bad++;
      end
      chk("R5_short", 8'(bad), 8'd0);
    end
    pwm = 0;
    tick(MIN_PW - 1);
    chk("R5_before", {4'b0, gate}, 8'h09);
    tick(2);
    chk("R6_release_first", {4'b0, gate}, 8'h08);
    tick(SETTLE);
    chk("R2", {4'b0, gate}, 8'h0A);

    // R7 / R8 thermal
    pwm = 1; dir = 0; brk = 0;
    tick(SETTLE);
    temp = 8'd100;
    tick(1);
    chk("R7_set", {7'b0, warn_n}, 8'h00);
    tick(4);
    chk("R7_no_gate_effect", {4'b0, gate}, 8'h06);
    temp = 8'd125;
    tick(2);
    chk("R8_off", {4'b0, gate}, 8'h00);
    chk("R8_flag", {5'b0, fault}, 8'h02);
    temp = 8'd117;
    tick(SETTLE);
    chk("R8_hyst_hold", {4'b0, gate}, 8'h00);
    temp = 8'd115;
    tick(SETTLE);
    chk("R8_clear", {4'b0, gate}, 8'h06);
    chk("R8_flag_clr", {5'b0, fault}, 8'h00);
    temp = 8'd97;
    tick(3);
    chk("R7_hyst_hold", {7'b0, warn_n}, 8'h00);
    temp = 8'd95;
    tick(2);
    chk("R7_clear", {7'b0, warn_n}, 8'h01);

    // R9 undervoltage
    vsup = 8'd79;
    tick(2);
    chk("R9_off", {4'b0, gate}, 8'h00);
    chk("R9_flag", {5'b0, fault}, 8'h04);
    vsup = 8'd85;
    tick(SETTLE);
    chk("R9_hyst_hold", {4'b0, gate}, 8'h00);
    vsup = 8'd86;
    tick(SETTLE);
    chk("R9_clear", {4'b0, gate}, 8'h06);

    // R10 single overcurrent pulse
    oc = 1;
    tick(1);
    oc = 0;
    chk("R10_flag", {5'b0, fault}, 8'h01);
    tick(1);
    chk("R10_off", {4'b0, gate}, 8'h00);
    tick(RETRY - 4);
    chk("R10_wait", {3'b0, fault, gate}, 8'h10);
    tick(DEAD + 10);
    chk("R10_resume", {3'b0, fault, gate}, 8'h06);

    // R10 held overcurrent keeps fault set through retries
    oc = 1;
    tick(1);
    begin
      int bad = 0;
      for (int i = 0; i < 3 * RETRY; i++) begin
        tick(1);
        if (fault[0] !== 1'b1) bad++;
      end
      chk("R10_held", 8'(bad), 8'd0);
    end
    oc = 0;
    tick(RETRY + DEAD + 10);
    chk("R10_recover", {3'b0, fault, gate}, 8'h06);

    // random command patterns
    for (int k = 0; k < 40; k++) begin
      logic [2:0] v;
      v = 3'($urandom());
      pwm = v[0]; dir = v[1]; brk = v[2];
      if (k % 4 == 0) begin
        pwm = ~pwm;
        tick(1 + int'($urandom() % (MIN_PW - 1)));
        pwm = v[0];
      end
      tick(SETTLE);
      chk(req_of(pwm, brk), {4'b0, gate}, {4'b0, exp_gate(pwm, dir, brk)});
    end

    finish_run();
  end
endmodule